// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the serial side of a small byte-wide memory. A bus master selects it with an active-low chip select. The master clocks command, address and data bytes in on the serial input, and the block answers on the serial output. The controller runs in a fast system clock domain. It oversamples the serial clock, chip select and data input through a synchronizer. It acts on the detected rising and falling edges of the serial clock, in SPI mode 0: the serial clock idles low, input bits are taken on the rising edge, and output bits change on the falling edge.

There are six one-byte commands:

- Two commands only change the write enable latch.
- Two commands read or write a status register.
- Two commands take a two-byte address and then stream bytes to or from an internal register array. The address steps after every byte and wraps at the top of the array.

Every write to the array or to the status register is refused unless the write enable latch is set. Finishing such a write clears the latch on its own, so the master must set it again before the next write. The serial clock must stay at least four system clocks in each level.

Top module: `spi_mem_slave`

## Requirements
- R1: After synchronous reset the status register reads 0x00 and the serial output enable is low.
- R2: Bytes are transferred most significant bit first. Input bits are taken on serial clock rising edges, and output bits change after serial clock falling edges, so they are stable at the next rising edge.
- R3: Command 0x06 sets the write enable latch, which is visible as status bit 1. Command 0x04 clears it.
- R4: Command 0x05 returns the status byte. Every further byte in the same selection returns it again. Status bits 0, 4, 5 and 6 always read 0.
- R5: With the latch set, command 0x01 followed by one byte stores data bits 7, 3 and 2 into status bits 7, 3 and 2. Data bit 1 never alters the latch.
- R6: Command 0x01 or command 0x02 issued while the latch is clear changes neither the array nor the status register.
- R7: Deselecting after at least one full data byte of a write clears the latch. A write deselected during its address phase leaves the latch set.
- R8: Command 0x03 (read) and command 0x02 (write) take a 16-bit address, high byte first. Only the low log2(DEPTH) bits select the array location.
- R9: Each further data byte of a read or write uses the next address, and the address wraps from DEPTH-1 to 0.
- R10: Deselecting at any point discards a partial byte and returns the decoder to expect a new command.
- R11: The serial output enable is low while deselected, and it is low whenever no status or array data is being shifted out.
- R12: An unknown command code is ignored, together with all bytes that follow it until deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the master, idles low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | High while spi_miso carries valid read data |

## Verification
The bench first loads the whole array through one long write burst. It then attacks the write-protection corners:

- A status write or array write with the latch clear. A design that ignores the latch would alter the status or the stored bytes.
- A write deselected during its address phase. A design that clears the latch at every deselect would report the latch as clear.
- A status write whose data has bit 1 set. A design that lets the status write reach the latch would leave it set.

Other directed cases cover:

- An address with high bits set, which an untruncated decoder would map elsewhere.
- A burst across the top of the array, which breaks if the address does not wrap.
- Three stray bits before a valid command, which shift the command by three bits if the bit counter is not reset on deselect.
- An unknown command whose trailing bytes must not drive the output.

A seeded random mix of all commands is then compared against a bench model.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADR_HI,
    PH_ADR_LO,
    PH_RD,
    PH_WR,
    PH_SR_RD,
    PH_SR_WR,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_in,
  input  logic sck_in,
  input  logic mosi_in,
  output logic cs_idle,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s
);
  logic [STAGES:0]   sck_pipe;
  logic [STAGES-1:0] cs_pipe;
  logic [STAGES-1:0] mosi_pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_pipe  <= '0;
      cs_pipe   <= '1;
      mosi_pipe <= '0;
    end else begin
      sck_pipe  <= {sck_pipe[STAGES-1:0], sck_in};
      cs_pipe   <= {cs_pipe[STAGES-2:0], cs_n_in};
      mosi_pipe <= {mosi_pipe[STAGES-2:0], mosi_in};
    end
  end

  assign sck_rise = sck_pipe[STAGES-1] & ~sck_pipe[STAGES];
  assign sck_fall = ~sck_pipe[STAGES-1] & sck_pipe[STAGES];
  assign cs_idle  = cs_pipe[STAGES-1];
  assign mosi_s   = mosi_pipe[STAGES-1];
endmodule

// File: rtl/spi_mem_ram.sv
module spi_mem_ram #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    q
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine
  import spi_mem_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_idle,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          mosi_s,
  input  logic [7:0]    ram_q,
  output logic          ram_we,
  output logic          ram_re,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  output logic          miso,
  output logic          miso_oe
);
  phase_t        phase;
  logic [2:0]    bit_cnt;
  logic [6:0]    rx_sh;
  logic [6:0]    tx_sh;
  logic          rd_op;
  logic [7:0]    addr_hi;
  logic [AW-1:0] addr;
  logic          wel;
  logic          wr_done;
  logic [2:0]    sr_keep;   // status bits 7, 3, 2

  logic [7:0]  rx_byte;
  logic        byte_done;
  logic [15:0] adr_full;
  logic [7:0]  status_val;
  logic [7:0]  tx_src;

  assign rx_byte    = {rx_sh, mosi_s};
  assign byte_done  = sck_rise && (bit_cnt == 3'd7);
  assign adr_full   = {addr_hi, rx_byte};
  assign status_val = {sr_keep[2], 3'b000, sr_keep[1], sr_keep[0], wel, 1'b0};
  assign tx_src     = (phase == PH_SR_RD) ? status_val : ram_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_CMD;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      rd_op     <= 1'b0;
      addr_hi   <= '0;
      addr      <= '0;
      wel       <= 1'b0;
      wr_done   <= 1'b0;
      sr_keep   <= '0;
      ram_we    <= 1'b0;
      ram_re    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      miso      <= 1'b0;
      miso_oe   <= 1'b0;
    end else begin
      ram_we <= 1'b0;
      ram_re <= 1'b0;
      if (cs_idle) begin
        phase   <= PH_CMD;
        bit_cnt <= '0;
        miso    <= 1'b0;
        miso_oe <= 1'b0;
        if (wr_done) begin
          wel     <= 1'b0;
          wr_done <= 1'b0;
        end
      end else begin
        if (sck_rise) begin
          bit_cnt <= bit_cnt + 3'd1;
          rx_sh   <= {rx_sh[5:0], mosi_s};
        end
        if (byte_done) begin
          unique case (phase)
            PH_CMD: begin
              case (rx_byte)
                OP_WREN: begin
                  wel   <= 1'b1;
                  phase <= PH_SKIP;
                end
                OP_WRDI: begin
                  wel   <= 1'b0;
                  phase <= PH_SKIP;
                end
                OP_RDSR:  phase <= PH_SR_RD;
                OP_WRSR:  phase <= wel ? PH_SR_WR : PH_SKIP;
                OP_READ: begin
                  rd_op <= 1'b1;
                  phase <= PH_ADR_HI;
                end
                OP_WRITE: begin
                  rd_op <= 1'b0;
                  phase <= wel ? PH_ADR_HI : PH_SKIP;
                end
                default:  phase <= PH_SKIP;
              endcase
            end
            PH_ADR_HI: begin
              addr_hi <= rx_byte;
              phase   <= PH_ADR_LO;
            end
            PH_ADR_LO: begin
              addr <= adr_full[AW-1:0];
              if (rd_op) begin
                ram_re   <= 1'b1;
                ram_addr <= adr_full[AW-1:0];
                phase    <= PH_RD;
              end else begin
                phase <= PH_WR;
              end
            end
            PH_RD: begin
              addr     <= addr + 1'b1;
              ram_re   <= 1'b1;
              ram_addr <= addr + 1'b1;
            end
            PH_WR: begin
              ram_we    <= 1'b1;
              ram_addr  <= addr;
              ram_wdata <= rx_byte;
              addr      <= addr + 1'b1;
              wr_done   <= 1'b1;
            end
            PH_SR_WR: begin
              if (!wr_done) begin
                sr_keep <= {rx_byte[7], rx_byte[3], rx_byte[2]};
                wr_done <= 1'b1;
              end
            end
            default: ;
          endcase
        end
        if (sck_fall) begin
          if (bit_cnt == 3'd0 && (phase == PH_RD || phase == PH_SR_RD)) begin
            miso    <= tx_src[7];
            tx_sh   <= tx_src[6:0];
            miso_oe <= 1'b1;
          end else if (miso_oe) begin
            miso  <= tx_sh[6];
            tx_sh <= {tx_sh[5:0], 1'b0};
          end
        end
      end
    end
  end

  AST_RAM_WE_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> wel); // R6
  AST_SR_LOCKED: assert property (@(posedge clk) disable iff (rst)
    !wel |=> $stable(sr_keep)); // R6
  AST_DONE_CLEARS_WEL: assert property (@(posedge clk) disable iff (rst)
    (cs_idle && wr_done) |=> !wel); // R7
  AST_SR_KEEPS_WEL: assert property (@(posedge clk) disable iff (rst)
    (byte_done && !cs_idle && phase == PH_SR_WR) |=> $stable(wel)); // R5
  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> (bit_cnt == 3'd0 && phase == PH_CMD)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> !miso_oe); // R11
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int DEPTH       = 1024,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  logic          cs_idle;
  logic          sck_rise;
  logic          sck_fall;
  logic          mosi_s;
  logic          ram_we;
  logic          ram_re;
  logic [AW-1:0] ram_addr;
  logic [7:0]    ram_wdata;
  logic [7:0]    ram_q;

  spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .cs_n_in  (spi_cs_n),
    .sck_in   (spi_sck),
    .mosi_in  (spi_mosi),
    .cs_idle  (cs_idle),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .mosi_s   (mosi_s)
  );

  spi_mem_engine #(.DEPTH(DEPTH)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .cs_idle   (cs_idle),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .mosi_s    (mosi_s),
    .ram_q     (ram_q),
    .ram_we    (ram_we),
    .ram_re    (ram_re),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .miso      (spi_miso),
    .miso_oe   (spi_miso_oe)
  );

  spi_mem_ram #(.DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .re    (ram_re),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .q     (ram_q)
  );
endmodule

// File: tb/spi_mem_slave_bench.sv
module spi_mem_slave_bench;
  localparam int DEPTH = 256;
  localparam int HALF  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso;
  logic miso_oe;

  int checks = 0;
  int fails  = 0;

  logic [7:0] ref_mem [DEPTH];
  logic [2:0] ref_sr  = 3'b000;
  logic       ref_wel = 1'b0;

  always #5 clk = ~clk;

  spi_mem_slave #(.DEPTH(DEPTH)) u_spi_mem_slave (
    .clk         (clk),
    .rst         (rst),
    .spi_cs_n    (cs_n),
    .spi_sck     (sck),
    .spi_mosi    (mosi),
    .spi_miso    (miso),
    .spi_miso_oe (miso_oe)
  );

  function automatic logic [7:0] exp_status();
    return {ref_sr[2], 3'b000, ref_sr[1], ref_sr[0], ref_wel, 1'b0};
  endfunction

  function automatic logic [7:0] fill_pat(input int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic desel();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  // Mode 0 byte: data set while SCK low, output sampled just before rising edge
  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                      output logic oe_any, output logic oe_all);
    oe_any = 1'b0;
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      wait_clk(HALF);
      rx[i]  = miso;
      oe_any = oe_any | miso_oe;
      oe_all = oe_all & miso_oe;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] tx, input string req);
    logic [7:0] rx;
    logic a, b;
    xfer(tx, rx, a, b);
    check8(req, {7'd0, a}, 8'h00);
  endtask

  task automatic cmd1(input logic [7:0] op);
    sel();
    send(op, "R11 oe during command");
    desel();
  endtask

  task automatic read_status(input string req, input int nbytes);
    logic [7:0] rx;
    logic a, b;
    sel();
    send(8'h05, "R11 oe during RDSR opcode");
    for (int k = 0; k < nbytes; k++) begin
      xfer(8'h00, rx, a, b);
      check8(req, rx, exp_status());
      check8("R11 oe while status shifted", {7'd0, b}, 8'h01);
    end
    desel();
  endtask

  task automatic wrsr(input logic [7:0] d);
    sel();
    send(8'h01, "R11 oe during WRSR");
    send(d, "R11 oe during WRSR data");
    desel();
    if (ref_wel) begin
      ref_sr  = {d[7], d[3], d[2]};
      ref_wel = 1'b0;
    end
  endtask

  task automatic write_burst(input logic [15:0] a, input int n, input bit use_pat);
    sel();
    send(8'h02, "R11 oe during WRITE");
    send(a[15:8], "R11 oe during address");
    send(a[7:0], "R11 oe during address");
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = use_pat ? fill_pat(k) : 8'($urandom);
      send(d, "R11 oe during write data");
      if (ref_wel) ref_mem[(int'(a) + k) % DEPTH] = d;
    end
    desel();
    if (n > 0) ref_wel = 1'b0;
  endtask

  task automatic read_burst(input logic [15:0] a, input int n, input string req);
    logic [7:0] rx;
    logic x, y;
    sel();
    send(8'h03, "R11 oe during READ");
    send(a[15:8], "R11 oe during address");
    send(a[7:0], "R11 oe during address");
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, rx, x, y);
      check8(req, rx, ref_mem[(int'(a) + k) % DEPTH]);
      check8("R11 oe while array data shifted", {7'd0, y}, 8'h01);
    end
    desel();
  endtask

  initial begin
    wait_clk(150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] rx;
    logic a, b;
    void'($urandom(32'h5EED));
    wait_clk(5);
    rst = 1'b0;
    wait_clk(4);

    // R1 reset state
    check8("R1 oe after reset", {7'd0, miso_oe}, 8'h00);
    read_status("R1 R4 status after reset", 1);

    // R6 status write refused while latch clear
    wrsr(8'hFF);
    read_status("R6 WRSR ignored without WEL", 1);

    // Fill the array, latch cleared after completion
    cmd1(8'h06); ref_wel = 1'b1;
    write_burst(16'h0000, DEPTH, 1'b1);
    read_status("R7 WEL cleared after write", 1);
    read_burst(16'h0000, 4, "R8 R2 read after fill");

    // R6 array write refused
    write_burst(16'h0005, 1, 1'b0);
    read_burst(16'h0005, 1, "R6 WRITE ignored without WEL");

    // R3 latch set and clear
    cmd1(8'h06); ref_wel = 1'b1;
    read_status("R3 WREN sets WEL", 1);
    cmd1(8'h04); ref_wel = 1'b0;
    read_status("R3 WRDI clears WEL", 1);

    // R5 status store, data bit 1 not reaching WEL
    cmd1(8'h06); ref_wel = 1'b1;
    wrsr(8'hFF);
    read_status("R5 WRSR stores bits 7 3 2", 3);
    cmd1(8'h06); ref_wel = 1'b1;
    wrsr(8'h02);
    read_status("R5 R4 WRSR data bit1 ignored", 2);

    // R7 write aborted in address phase keeps latch
    cmd1(8'h06); ref_wel = 1'b1;
    sel();
    send(8'h02, "R11 oe during WRITE");
    send(8'h00, "R11 oe during address");
    desel();
    read_status("R7 aborted WRITE keeps WEL", 1);

    // R8 high address bits ignored (latch still set)
    write_burst(16'h1234, 1, 1'b0);
    read_burst(16'h0034, 1, "R8 high address bits dropped");

    // R9 wrap at top of array
    cmd1(8'h06); ref_wel = 1'b1;
    write_burst(16'(DEPTH - 1), 2, 1'b0);
    read_burst(16'(DEPTH - 2), 4, "R9 address wraps");

    // R10 stray bits discarded by deselect
    sel();
    for (int i = 0; i < 3; i++) begin
      mosi = 1'b1;
      wait_clk(HALF);
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
    desel();
    cmd1(8'h06); ref_wel = 1'b1;
    read_status("R10 command aligned after partial byte", 1);
    cmd1(8'h04); ref_wel = 1'b0;

    // R12 unknown opcode
    sel();
    send(8'h9F, "R12 R11 oe after unknown opcode");
    xfer(8'h06, rx, a, b);
    check8("R12 R11 no output on trailing bytes", {7'd0, a}, 8'h00);
    send(8'h01, "R12 R11 no output on trailing bytes");
    desel();
    read_status("R12 unknown opcode no effect", 1);

    // Constrained random mix
    for (int it = 0; it < 40; it++) begin
      int op;
      op = int'($urandom % 4);
      if (op == 0) begin
        if ($urandom % 4 != 0) begin cmd1(8'h06); ref_wel = 1'b1; end
        write_burst(16'($urandom), 1 + int'($urandom % 4), 1'b0);
      end else if (op == 1) begin
        read_burst(16'($urandom), 1 + int'($urandom % 4), "R8 R9 random read");
      end else if (op == 2) begin
        if ($urandom % 2 != 0) begin cmd1(8'h06); ref_wel = 1'b1; end
        wrsr(8'($urandom));
      end else begin
        read_status("R4 R5 random status", 1 + int'($urandom % 2));
      end
    end

    finish_run();
  end
endmodule